// File: doc/BRIEF.md
# Parallel Port with Timed Strobe and Input Interrupt

This block is an eight-bit general-purpose port driven by a small command interface. Each of the eight lines has its own direction bit. A line whose direction bit is 1 drives the output data register onto the pad. A line whose direction bit is 0 is left high-impedance: its output enable is low and its output value is held at 0. Each write to the output data register starts an output strobe pulse. The pulse width is one of four fixed durations, measured in clock cycles of the block's clock.

An input strobe line captures the pad inputs into a capture register. It can work in one of two ways. In edge mode it captures only on the rising edge of the strobe. In level mode it captures on every cycle that the strobe is high. Every capture event sets an interrupt-pending flag. The interrupt output is that flag gated by an enable bit in the control register. A status read returns the pending flag and an invalid-command flag, then clears both. A dedicated clear command clears only the pending flag. An opcode that is not defined sets the invalid-command flag and changes nothing else.

Top module: `pp_port`

## Requirements
- R1: Command 0x1 loads the direction register from cmd_wdata and pad_oe follows it in the next cycle. Command 0x2 reads the register back. After reset the direction register is 0x00.
- R2: Command 0x3 loads the output data register. pad_out equals that register ANDed with the direction register, so every line with pad_oe low drives 0.
- R3: out_strobe goes high in the cycle after command 0x3 and stays high for exactly 4, 8, 20 or 40 cycles, for control bits [1:0] = 0, 1, 2, 3. These are 100, 200, 500 and 1000 ns at the default 40 MHz.
- R4: A command 0x3 issued while the strobe is active restarts the full width. The strobe does not drop in between.
- R5: With control bit [2] = 1 (edge mode), pad_in is captured only on the cycle where in_strobe rises. Command 0x5 reads the capture register.
- R6: With control bit [2] = 0 (level mode), pad_in is captured on every cycle that in_strobe is high.
- R7: Every capture event sets the pending flag. irq equals the pending flag ANDed with control bit [3], so a flag set while irq is masked is raised once the mask bit is set.
- R8: Command 0x8 returns {6'b0, invalid, pending} and clears both flags. Command 0x9 clears pending only. A capture event in the same cycle as a clear leaves pending set.
- R9: Opcodes 0x0 and 0xA–0xF set the invalid flag and leave the direction, data and control registers unchanged.
- R10: A read command (0x2, 0x4, 0x5, 0x7, 0x8) gives rsp_valid high for one cycle, one cycle later, with its data. Command 0x4 returns pad_in. Command 0x7 returns {4'b0, control[3:0]}. Command 0x6 writes the control register from cmd_wdata[3:0].
- R11: After reset, pad_oe, pad_out, out_strobe, irq and rsp_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_wdata | input | 8 | Command write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Per-line output enable |
| in_strobe | input | 1 | Input strobe line |
| out_strobe | output | 1 | Output strobe pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all 256 direction masks against a fixed data pattern. A design that leaked data onto an input line would show a nonzero pad_out bit where pad_oe is low. It measures the strobe length for each of the four width codes, and again after a retrigger in mid-pulse. An off-by-one counter, or a design that ignored the retrigger, gives a wrong cycle count. It changes pad_in while in_strobe is held high. In edge mode a wrong design would recapture, and in level mode a wrong design would miss the later value. It also issues a clear in the same cycle as a capture event, sets the pending flag while irq is masked and then unmasks it, and sends every undefined opcode. A design that got the order of these wrong would lose an interrupt or corrupt a register.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [3:0] {
        OP_WR_DIR  = 4'h1,
        OP_RD_DIR  = 4'h2,
        OP_WR_OUT  = 4'h3,
        OP_RD_PINS = 4'h4,
        OP_RD_CAP  = 4'h5,
        OP_WR_CTRL = 4'h6,
        OP_RD_CTRL = 4'h7,
        OP_RD_STAT = 4'h8,
        OP_CLR_IRQ = 4'h9
    } pp_op_e;

    typedef struct packed {
        logic       irq_en;
        logic       edge_mode;
        logic [1:0] wsel;
    } pp_ctrl_t;

    typedef struct packed {
        logic wr_dir;
        logic wr_out;
        logic wr_ctrl;
        logic rd_any;
        logic rd_stat;
        logic clr_irq;
        logic invalid;
    } pp_dec_t;

endpackage

// File: rtl/pp_cmd_decode.sv
module pp_cmd_decode
    import pp_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    output pp_dec_t    dec
);
    always_comb begin
        dec = '0;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_WR_DIR:  dec.wr_dir  = 1'b1;
                OP_WR_OUT:  dec.wr_out  = 1'b1;
                OP_WR_CTRL: dec.wr_ctrl = 1'b1;
                OP_RD_DIR, OP_RD_PINS, OP_RD_CAP, OP_RD_CTRL:
                            dec.rd_any  = 1'b1;
                OP_RD_STAT: begin
                    dec.rd_any  = 1'b1;
                    dec.rd_stat = 1'b1;
                end
                OP_CLR_IRQ: dec.clr_irq = 1'b1;
                default:    dec.invalid = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/pp_strobe_gen.sv
module pp_strobe_gen #(
    parameter int CLK_MHZ = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] wsel,
    output logic       strobe
);
    localparam int W0 = 100  * CLK_MHZ / 1000;
    localparam int W1 = 200  * CLK_MHZ / 1000;
    localparam int W2 = 500  * CLK_MHZ / 1000;
    localparam int W3 = 1000 * CLK_MHZ / 1000;
    localparam int CW = $clog2(W3 + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } sg_state_t;

    sg_state_t st_d, st_q;
    logic [CW-1:0] load_val;

    always_comb begin
        unique case (wsel)
            2'd0:    load_val = CW'(W0);
            2'd1:    load_val = CW'(W1);
            2'd2:    load_val = CW'(W2);
            default: load_val = CW'(W3);
        endcase
        st_d = st_q;
        if (start) begin
            st_d.cnt = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = (st_q.cnt != '0);
endmodule

// File: rtl/pp_in_capture.sv
module pp_in_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_strobe,
    input  logic [W-1:0] pad_in,
    input  logic         edge_mode,
    output logic         event_o,
    output logic [W-1:0] cap_o
);
    typedef struct packed {
        logic         prev;
        logic [W-1:0] cap;
    } ic_state_t;

    ic_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = in_strobe;
        if (edge_mode) event_o = in_strobe & ~st_q.prev;
        else           event_o = in_strobe;
        if (event_o) st_d.cap = pad_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o = st_q.cap;
endmodule

// File: rtl/pp_port.sv
module pp_port
    import pp_pkg::*;
#(
    parameter int CLK_MHZ = 40,
    parameter int W       = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [3:0]   cmd_op,
    input  logic [W-1:0] cmd_wdata,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_data,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    input  logic         in_strobe,
    output logic         out_strobe,
    output logic         irq
);
    localparam int CTRL_W = $bits(pp_ctrl_t);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        pp_ctrl_t     ctrl;
        logic         pending;
        logic         inv;
        logic         rsp_valid;
        logic [W-1:0] rsp_data;
    } pt_state_t;

    pt_state_t st_d, st_q;
    pp_dec_t   dec;
    logic          cap_event;
    logic [W-1:0]  cap_val;
    logic          pending;
    logic          inv_flag;

    pp_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .dec       (dec)
    );

    pp_strobe_gen #(.CLK_MHZ(CLK_MHZ)) u_sg (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (dec.wr_out),
        .wsel   (st_q.ctrl.wsel),
        .strobe (out_strobe)
    );

    pp_in_capture #(.W(W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_strobe (in_strobe),
        .pad_in    (pad_in),
        .edge_mode (st_q.ctrl.edge_mode),
        .event_o   (cap_event),
        .cap_o     (cap_val)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = dec.rd_any;
        st_d.rsp_data  = '0;

        if (dec.wr_dir)  st_d.dir  = cmd_wdata;
        if (dec.wr_out)  st_d.dout = cmd_wdata;
        if (dec.wr_ctrl) st_d.ctrl = pp_ctrl_t'(cmd_wdata[CTRL_W-1:0]);

        if (dec.rd_any) begin
            unique case (cmd_op)
                OP_RD_DIR:  st_d.rsp_data = st_q.dir;
                OP_RD_PINS: st_d.rsp_data = pad_in;
                OP_RD_CAP:  st_d.rsp_data = cap_val;
                OP_RD_CTRL: st_d.rsp_data = W'(st_q.ctrl);
                default:    st_d.rsp_data = W'({st_q.inv, st_q.pending});
            endcase
        end

        if (dec.rd_stat || dec.clr_irq) st_d.pending = 1'b0;
        if (cap_event)                  st_d.pending = 1'b1;

        if (dec.rd_stat) st_d.inv = 1'b0;
        if (dec.invalid) st_d.inv = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pad_oe    = st_q.dir;
    assign pad_out   = st_q.dout & st_q.dir;
    assign pending   = st_q.pending;
    assign inv_flag  = st_q.inv;
    assign irq       = st_q.pending & st_q.ctrl.irq_en;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
endmodule

// File: rtl/pp_port_chk.sv
module pp_port_chk #(
    parameter int CLK_MHZ = 40,
    parameter int W       = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic [3:0]   cmd_op,
    input logic [W-1:0] cmd_wdata,
    input logic         rsp_valid,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic         in_strobe,
    input logic         out_strobe,
    input logic         irq,
    input logic         inv_flag
);
    localparam int WMAX = 1000 * CLK_MHZ / 1000;
    localparam int RW   = $clog2(WMAX + 2);

    logic [RW-1:0] run_q;
    logic is_rd, is_bad, is_wout;

    assign is_rd   = cmd_valid && (cmd_op == 4'h2 || cmd_op == 4'h4 || cmd_op == 4'h5
                                   || cmd_op == 4'h7 || cmd_op == 4'h8);
    assign is_bad  = cmd_valid && (cmd_op == 4'h0 || cmd_op > 4'h9);
    assign is_wout = cmd_valid && cmd_op == 4'h3;

    always_ff @(posedge clk) begin
        if (!rst_n || is_wout)               run_q <= '0;
        else if (out_strobe && run_q != '1)  run_q <= run_q + 1'b1;
        else if (!out_strobe)                run_q <= '0;
    end

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 4'h1 |=> pad_oe == $past(cmd_wdata)); // R1
    AST_NO_DRIVE_WHEN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0); // R2
    AST_STROBE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        is_wout |=> out_strobe); // R3
    AST_STROBE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(WMAX)); // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(in_strobe) || $past(cmd_valid && cmd_op == 4'h6)); // R7
    AST_INVALID_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        is_bad |=> inv_flag); // R9
    AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(is_rd)); // R10
endmodule

bind pp_port pp_port_chk #(.CLK_MHZ(CLK_MHZ), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .rsp_valid  (rsp_valid),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .in_strobe  (in_strobe),
    .out_strobe (out_strobe),
    .irq        (irq),
    .inv_flag   (inv_flag)
);

// File: tb/pp_port_bench.sv
module pp_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [7:0] cmd_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic       in_strobe = 1'b0;
    logic       out_strobe;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pp_port u_pp_port (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .in_strobe(in_strobe), .out_strobe(out_strobe), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmd(logic [3:0] op, logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(logic [3:0] op, output logic [7:0] v);
        cmd(op, 8'h00);
        chk("R10 rsp_valid", int'(rsp_valid), 1);
        v = rsp_data;
        @(negedge clk);
        chk("R10 rsp_valid pulse", int'(rsp_valid), 0);
    endtask

    task automatic measure(output int n);
        n = 0;
        while (out_strobe && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        int widths[4] = '{4, 8, 20, 40};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 pad_oe", int'(pad_oe), 0);
        chk("R11 pad_out", int'(pad_out), 0);
        chk("R11 out_strobe", int'(out_strobe), 0);
        chk("R11 irq", int'(irq), 0);
        chk("R11 rsp_valid", int'(rsp_valid), 0);
        rd(4'h2, v); chk("R1 dir reset", int'(v), 0);

        // R1 R2 direction sweep
        cmd(4'h3, 8'h5A);
        for (int d = 0; d < 256; d++) begin
            cmd(4'h1, 8'(d));
            chk("R1 pad_oe", int'(pad_oe), d);
            chk("R2 pad_out masked", int'(pad_out), d & 8'h5A);
        end
        rd(4'h2, v); chk("R1 dir readback", int'(v), 8'hFF);
        cmd(4'h3, 8'hC3);
        chk("R2 pad_out full", int'(pad_out), 8'hC3);
        repeat (50) @(negedge clk);

        // R3 width per code, R4 retrigger
        for (int w = 0; w < 4; w++) begin
            cmd(4'h6, 8'(w));
            cmd(4'h3, 8'(w));
            measure(n);
            chk("R3 strobe width", n, widths[w]);
            cmd(4'h3, 8'h10);
            repeat (3) @(negedge clk);
            chk("R4 strobe mid", int'(out_strobe), 1);
            cmd(4'h3, 8'h20);
            measure(n);
            chk("R4 retrigger width", n, widths[w]);
        end

        // R10 control/pins reads
        cmd(4'h6, 8'hFB);
        rd(4'h7, v); chk("R10 ctrl readback", int'(v), 8'h0B);
        pad_in = 8'h96;
        rd(4'h4, v); chk("R10 pins read", int'(v), 8'h96);

        // R5 edge mode with irq enabled
        cmd(4'h6, 8'h0C);
        rd(4'h8, v);
        pad_in = 8'hA5; in_strobe = 1'b1;
        @(negedge clk);
        pad_in = 8'h3C;
        repeat (2) @(negedge clk);
        rd(4'h5, v); chk("R5 edge capture", int'(v), 8'hA5);
        chk("R7 irq raised", int'(irq), 1);
        in_strobe = 1'b0;
        rd(4'h8, v); chk("R8 status pending", int'(v), 1);
        rd(4'h8, v); chk("R8 status cleared", int'(v), 0);
        chk("R8 irq cleared", int'(irq), 0);

        // R6 level mode
        cmd(4'h6, 8'h08);
        in_strobe = 1'b1; pad_in = 8'h11;
        @(negedge clk);
        pad_in = 8'h22;
        @(negedge clk);
        in_strobe = 1'b0; pad_in = 8'h33;
        @(negedge clk);
        rd(4'h5, v); chk("R6 level capture", int'(v), 8'h22);

        // R7 masked, then unmasked
        cmd(4'h6, 8'h04);
        rd(4'h8, v);
        in_strobe = 1'b1;
        @(negedge clk);
        in_strobe = 1'b0;
        @(negedge clk);
        chk("R7 irq masked", int'(irq), 0);
        cmd(4'h6, 8'h0C);
        chk("R7 irq after unmask", int'(irq), 1);

        // R8 clear command, then clear racing an event
        cmd(4'h9, 8'h00);
        chk("R8 clr irq", int'(irq), 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'h9; in_strobe = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; in_strobe = 1'b0;
        rd(4'h8, v); chk("R8 event beats clear", int'(v), 1);

        // R9 every undefined opcode
        cmd(4'h1, 8'h3C);
        cmd(4'h6, 8'h02);
        for (int op = 0; op < 16; op++) begin
            if (op >= 1 && op <= 9) continue;
            cmd(4'(op), 8'hFF);
            rd(4'h8, v); chk("R9 invalid flag", int'(v), 2);
            chk("R9 dir kept", int'(pad_oe), 8'h3C);
            rd(4'h7, v); chk("R9 ctrl kept", int'(v), 2);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule